// File: doc/BRIEF.md
# Min-max variable node update unit

This unit performs the variable-node step of a non-binary min-max LDPC decoder over a 32-element field. It handles one variable node at a time. The caller first pulses `start`. It then streams the 32 field elements in index order. Each accepted beat carries the channel LLR for one element and the LLRs that the three adjacent checks hold for that element. A smaller LLR means a more likely symbol. For each element and each adjacent check, the unit adds the channel value to the messages of the other two checks. It saturates the sum and stores it. It keeps a running minimum per outgoing edge. It also keeps the smallest a-posteriori value (channel value plus all three messages) together with the index where that value occurs.

Once all 32 elements have been loaded, the unit streams the three outgoing vectors back, one element per beat, in index order. Each vector has its own minimum subtracted, so its smallest entry is zero. The hard-decision symbol is presented during output. A one-cycle completion pulse follows the last output beat.

Top module: `vnu_minmax_update`

## Requirements
- R1: Outgoing edge e, element a, equals the channel LLR of a plus the check LLRs of a from the two edges other than e, minus that edge's minimum. Edge k sits at bits [k*5 +: 5] of both message buses.
- R2: Every sum saturates at 31 and never wraps, both for the extrinsic sums and for the a-posteriori sums.
- R3: Each outgoing vector has non-negative entries, and at least one of its 32 entries is exactly zero.
- R4: `hard_sym` is the index of the smallest a-posteriori value. A tie goes to the lowest index. The value is valid from the first output beat until the next `start`, and it stays constant throughout output.
- R5: `in_ready` is high only while loading. Exactly 32 beats with `in_valid && in_ready` are taken. A cycle with `in_valid` low has no effect on the results, whatever the data lines carry.
- R6: The output presents elements 0 to 31 in order on `out_idx`. While `out_valid` is high and `out_ready` is low, the index and data hold steady.
- R7: `done` is high for exactly one cycle, in the cycle after the handshake of element 31. After that, both `in_ready` and `out_valid` are low until the next `start`.
- R8: A `start` pulse at any time discards any partial load. Results then come only from the 32 beats accepted after the pulse.
- R9: After reset, `in_ready`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the accumulators and begins a new load |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit accepts an input beat |
| in_chn_llr | input | 5 | Channel LLR of the current element |
| in_c2v_llr | input | 15 | Check-to-variable LLRs of the current element, one 5-bit field per edge |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_idx | output | 5 | Field element index of the output beat |
| out_v2c_llr | output | 15 | Normalized outgoing LLRs, one 5-bit field per edge |
| hard_sym | output | 5 | Hard-decision symbol |
| done | output | 1 | One-cycle pulse after the last output beat |

## Verification
The bench uses several vector sets.
- An all-zero input and a set with an equal a-posteriori minimum at two inner indices test the tie rule. A design that chose the later index, or that replaced its stored minimum on equality, would report the wrong symbol.
- Sets that are all maximum, or nearly so, push every sum past the 5-bit range. A wrapping adder would give small values, and those would wrongly win the minimum.
- Random gaps on the input and random back-pressure on the output test flow control. A design that advanced its index on a dead cycle, or that let data change while stalled, would shift or corrupt the vectors.
- A restart in the middle of a load tests that stale partial minima are cleared. Without the clear, the stale minima would leak into the next node's normalization.

// File: rtl/vnu_pkg.sv
package vnu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_EMIT = 2'd2
    } vnu_state_e;

endpackage

// File: rtl/vnu_edge_sum.sv
// Forms the saturated a-posteriori sum and, per edge, the saturated extrinsic sum
module vnu_edge_sum #(
    parameter int W  = 5,
    parameter int DV = 3
) (
    input  logic [W-1:0]    chn,
    input  logic [DV*W-1:0] c2v,
    output logic [DV*W-1:0] ext,
    output logic [W-1:0]    app
);
    localparam int SW = W + $clog2(DV + 1);
    localparam logic [SW-1:0] MAXV = SW'((1 << W) - 1);

    function automatic logic [W-1:0] clamp(input logic [SW-1:0] v);
        return (v > MAXV) ? MAXV[W-1:0] : v[W-1:0];
    endfunction

    logic [SW-1:0] total;

    always_comb begin
        total = SW'(chn);
        for (int k = 0; k < DV; k++) begin
            total = total + SW'(c2v[k*W +: W]);
        end
    end

    assign app = clamp(total);

    // the full sum minus the own edge leaves every other edge plus the channel
    for (genvar e = 0; e < DV; e++) begin : g_ext
        assign ext[e*W +: W] = clamp(total - SW'(c2v[e*W +: W]));
    end
endmodule

// File: rtl/vnu_min_pick.sv
// Decides whether a candidate replaces the running minimum (strictly smaller wins)
module vnu_min_pick #(
    parameter int W = 5
) (
    input  logic         first,
    input  logic [W-1:0] cand,
    input  logic [W-1:0] cur,
    output logic         take
);
    assign take = first || (cand < cur);
endmodule

// File: rtl/vnu_vec_store.sv
// Register file that holds the unnormalized extrinsic sums of every element
module vnu_vec_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 15
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/vnu_minmax_update.sv
module vnu_minmax_update #(
    parameter int W  = 5,
    parameter int DV = 3,
    parameter int Q  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [W-1:0]            in_chn_llr,
    input  logic [DV*W-1:0]         in_c2v_llr,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [$clog2(Q)-1:0]    out_idx,
    output logic [DV*W-1:0]         out_v2c_llr,
    output logic [$clog2(Q)-1:0]    hard_sym,
    output logic                    done
);
    import vnu_pkg::*;

    localparam int QW = $clog2(Q);
    localparam int DW = DV * W;
    localparam logic [QW-1:0] LAST = QW'(Q - 1);

    typedef struct packed {
        vnu_state_e             st;
        logic [QW-1:0]          idx;
        logic [DV-1:0][W-1:0]   emin;
        logic [W-1:0]           amin;
        logic [QW-1:0]          asym;
        logic                   done;
    } ctl_t;

    ctl_t c_q, c_d;

    logic [DW-1:0] ext;
    logic [W-1:0]  app;
    logic [DW-1:0] rd;
    logic [DV-1:0] take_e;
    logic          take_a;
    logic          first;
    logic          we;

    vnu_edge_sum #(.W(W), .DV(DV)) u_sum (
        .chn (in_chn_llr),
        .c2v (in_c2v_llr),
        .ext (ext),
        .app (app)
    );

    for (genvar e = 0; e < DV; e++) begin : g_edge
        vnu_min_pick #(.W(W)) u_pick (
            .first (first),
            .cand  (ext[e*W +: W]),
            .cur   (c_q.emin[e]),
            .take  (take_e[e])
        );
        // stored sum never falls below the stored minimum of its edge
        assign out_v2c_llr[e*W +: W] = rd[e*W +: W] - c_q.emin[e];
    end

    vnu_min_pick #(.W(W)) u_apick (
        .first (first),
        .cand  (app),
        .cur   (c_q.amin),
        .take  (take_a)
    );

    vnu_vec_store #(.DEPTH(Q), .DW(DW)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (c_q.idx),
        .wdata (ext),
        .raddr (c_q.idx),
        .rdata (rd)
    );

    assign first     = (c_q.idx == '0);
    assign in_ready  = (c_q.st == ST_LOAD) && !start;
    assign we        = in_valid && in_ready;
    assign out_valid = (c_q.st == ST_EMIT);
    assign out_idx   = c_q.idx;
    assign hard_sym  = c_q.asym;
    assign done      = c_q.done;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        if (start) begin
            c_d.st   = ST_LOAD;
            c_d.idx  = '0;
            c_d.emin = '1;
            c_d.amin = '1;
            c_d.asym = '0;
        end else begin
            unique case (c_q.st)
                ST_LOAD: begin
                    if (in_valid) begin
                        for (int e = 0; e < DV; e++) begin
                            if (take_e[e]) begin
                                c_d.emin[e] = ext[e*W +: W];
                            end
                        end
                        if (take_a) begin
                            c_d.amin = app;
                            c_d.asym = c_q.idx;
                        end
                        if (c_q.idx == LAST) begin
                            c_d.st  = ST_EMIT;
                            c_d.idx = '0;
                        end else begin
                            c_d.idx = c_q.idx + 1'b1;
                        end
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        if (c_q.idx == LAST) begin
                            c_d.st   = ST_IDLE;
                            c_d.idx  = '0;
                            c_d.done = 1'b1;
                        end else begin
                            c_d.idx = c_q.idx + 1'b1;
                        end
                    end
                end
                default: begin
                    c_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, idx: '0, emin: '0, amin: '0, asym: '0, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/vnu_minmax_update_chk.sv
module vnu_minmax_update_chk #(
    parameter int W  = 5,
    parameter int DV = 3,
    parameter int Q  = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [$clog2(Q)-1:0] out_idx,
    input logic [DV*W-1:0]      out_v2c_llr,
    input logic [$clog2(Q)-1:0] hard_sym,
    input logic                 done
);
    localparam logic [$clog2(Q)-1:0] LAST = $clog2(Q)'(Q - 1);

    p_mutex_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=>
            (out_valid && $stable(out_idx) && $stable(out_v2c_llr)));

    p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_idx != LAST && !start) |=>
            (out_valid && out_idx == $past(out_idx) + 1'b1));

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid && out_ready && out_idx == LAST && !start)
                  && !out_valid && !in_ready));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hard_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !start) |=> $stable(hard_sym));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!out_valid && !done));
endmodule

bind vnu_minmax_update vnu_minmax_update_chk #(.W(W), .DV(DV), .Q(Q)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_idx     (out_idx),
    .out_v2c_llr (out_v2c_llr),
    .hard_sym    (hard_sym),
    .done        (done)
);

// File: tb/test_vnu_minmax_update.sv
module test_vnu_minmax_update;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 5;
    localparam int DV   = 3;
    localparam int Q    = 32;
    localparam int QW   = 5;
    localparam int MAXV = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic out_ready = 1'b0;
    logic [W-1:0]    in_chn_llr = '0;
    logic [DV*W-1:0] in_c2v_llr = '0;
    logic            in_ready, out_valid, done;
    logic [QW-1:0]   out_idx, hard_sym;
    logic [DV*W-1:0] out_v2c_llr;

    vnu_minmax_update i_vnu_minmax_update (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_chn_llr(in_chn_llr), .in_c2v_llr(in_c2v_llr),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_idx(out_idx), .out_v2c_llr(out_v2c_llr),
        .hard_sym(hard_sym), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [QW-1:0]   idx;
        logic [DV*W-1:0] v;
        logic [QW-1:0]   hs;
    } exp_t;

    exp_t  expq[$];
    int    chn[Q];
    int    c2v[DV][Q];
    int    n_checks = 0;
    int    n_fail = 0;
    int    rdy_mode = 0;
    int    vec_done = 0;
    int    done_wait = 0;
    string cur_req = "R1";
    logic [DV-1:0]   zero_seen = '0;
    logic            held = 1'b0;
    logic [QW-1:0]   held_idx = '0;
    logic [DV*W-1:0] held_v = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    task automatic build_expect();
        int ext[DV][Q];
        int mn[DV];
        int best, hs;
        best = 1000;
        hs = 0;
        for (int e = 0; e < DV; e++) mn[e] = 1000;
        for (int a = 0; a < Q; a++) begin
            int tot;
            tot = chn[a];
            for (int k = 0; k < DV; k++) tot += c2v[k][a];
            if (sat(tot) < best) begin
                best = sat(tot);
                hs = a;
            end
            for (int e = 0; e < DV; e++) begin
                ext[e][a] = sat(tot - c2v[e][a]);
                if (ext[e][a] < mn[e]) mn[e] = ext[e][a];
            end
        end
        for (int a = 0; a < Q; a++) begin
            exp_t x;
            x.idx = QW'(a);
            x.hs  = QW'(hs);
            for (int e = 0; e < DV; e++) x.v[e*W +: W] = W'(ext[e][a] - mn[e]);
            expq.push_back(x);
        end
    endtask

    task automatic fill(input int mode);
        for (int a = 0; a < Q; a++) begin
            case (mode)
                1: chn[a] = 0;
                2: chn[a] = MAXV;
                3: chn[a] = $urandom_range(20, 31);
                4: chn[a] = (a == 5 || a == 9) ? 4 : 20;
                default: chn[a] = $urandom_range(0, 31);
            endcase
            for (int e = 0; e < DV; e++) begin
                case (mode)
                    1: c2v[e][a] = 0;
                    2: c2v[e][a] = MAXV;
                    3: c2v[e][a] = $urandom_range(10, 31);
                    4: c2v[e][a] = 3;
                    default: c2v[e][a] = $urandom_range(0, 31);
                endcase
            end
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic feed(input int n, input bit gaps, input bit junk);
        for (int a = 0; a < n; a++) begin
            if (gaps && $urandom_range(0, 2) == 0) begin
                in_valid   = 1'b0;
                in_chn_llr = W'($urandom);
                in_c2v_llr = (DV*W)'($urandom);
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            if (junk) begin
                in_chn_llr = W'($urandom);
                in_c2v_llr = (DV*W)'($urandom);
            end else begin
                in_chn_llr = W'(chn[a]);
                for (int e = 0; e < DV; e++) in_c2v_llr[e*W +: W] = W'(c2v[e][a]);
            end
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic run_vector(input int mode, input bit gaps, input string req);
        int target;
        cur_req = req;
        fill(mode);
        build_expect();
        zero_seen = '0;
        target = vec_done + 1;
        pulse_start();
        feed(Q, gaps, 1'b0);
        wait (vec_done >= target);
        check(zero_seen == '1, "R3", "zero entry per outgoing vector", int'(zero_seen), 7);
        @(posedge clk); #1;
    endtask

    // output ready driver
    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = (rdy_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
        end
    end

    // scoreboard monitor, sampling mid-cycle
    always @(negedge clk) begin
        if (done_wait == 2) begin
            check(done == 1'b1, "R7", "done after last beat", int'(done), 1);
            check(!in_ready && !out_valid, "R7", "quiet after done",
                  int'({in_ready, out_valid}), 0);
            done_wait = 1;
        end else if (done_wait == 1) begin
            check(done == 1'b0, "R7", "done lasts one cycle", int'(done), 0);
            done_wait = 0;
            vec_done++;
        end
        if (held) begin
            check(out_valid && out_idx == held_idx && out_v2c_llr == held_v, "R6",
                  "hold under back-pressure", int'(out_v2c_llr), int'(held_v));
        end
        held = out_valid && !out_ready;
        held_idx = out_idx;
        held_v = out_v2c_llr;
        if (out_valid) begin
            check(!in_ready, "R5", "in_ready low while emitting", int'(in_ready), 0);
        end
        if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
                check(1'b0, cur_req, "unexpected output beat", int'(out_idx), -1);
            end else begin
                exp_t x;
                x = expq.pop_front();
                check(out_idx == x.idx, "R6", "element order", int'(out_idx), int'(x.idx));
                check(out_v2c_llr == x.v, cur_req, "outgoing LLRs (R1)",
                      int'(out_v2c_llr), int'(x.v));
                check(hard_sym == x.hs, "R4", "hard decision", int'(hard_sym), int'(x.hs));
                for (int e = 0; e < DV; e++) begin
                    if (out_v2c_llr[e*W +: W] == '0) zero_seen[e] = 1'b1;
                end
                if (x.idx == QW'(Q - 1)) done_wait = 2;
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!in_ready && !out_valid && !done, "R9", "reset outputs",
              int'({in_ready, out_valid, done}), 0);
        @(posedge clk); #1;

        run_vector(0, 1'b0, "R1");
        rdy_mode = 1;
        run_vector(0, 1'b1, "R5");
        rdy_mode = 0;
        run_vector(1, 1'b0, "R4");
        run_vector(2, 1'b0, "R2");
        rdy_mode = 1;
        run_vector(3, 1'b1, "R2");
        run_vector(4, 1'b0, "R4");
        // R8: partial junk load, then a restart with real data
        cur_req = "R8";
        pulse_start();
        feed(10, 1'b0, 1'b1);
        run_vector(0, 1'b1, "R8");
        rdy_mode = 0;
        run_vector(0, 1'b0, "R3");

        check(expq.size() == 0, "R6", "all expected beats seen", expq.size(), 0);
        summary();
    end
endmodule